// File: doc/BRIEF.md
# Instruction fetch sequencer

This block is the front stage of a pipelined processor whose instructions are 16-bit words. It owns the word-address program counter, computes the address that the synchronous program memory reads next, and receives back a 32-bit window from that memory. The low half of the window is the word at the current counter and the high half is the word after it. The stage hands the next pipeline stage a 32-bit opcode, the counter value that belongs to that opcode, and a flag that marks the first cycle of an instruction.

The next counter value follows a fixed order of precedence. A clear input forces zero. A self-generated stall holds the value. A branch load from the execution stage takes a supplied address. A two-word instruction advances by two. Any other instruction advances by one. The stage decodes a small set of multi-cycle instructions and stalls itself for exactly one cycle on each of them. It also rewrites its opcode output: a clear or a skip turns it into an all-zero no-op, and a pending interrupt turns it into a pseudo-opcode that carries the vector number.

The memory address output is driven combinationally from the next-counter logic, so that the registered memory data lines up with the registered counter one clock later. The clear input also serves as the block's synchronous, active-high reset.

Top module: `fetch_seq`

## Requirements
- R1: While `clr` is 1, `mem_addr` is 0 and `opc_out` is 0. After a clock edge with `clr` at 1, `pc_out` is 0 and `first_cycle` is 1.
- R2: While the stage stalls, `mem_addr` equals `pc_out`, so the counter holds. A stall wins over a branch load.
- R3: Without clear or stall, `load_pc` at 1 makes `mem_addr` equal `new_pc`, even when the current word is a two-word instruction.
- R4: Without clear, stall or load, a current word (`mem_opc[15:0]`) is two-word when bits 15:9 are 1001010 and bits 3:2 are 11, or when bits 15:10 are 100100 and bits 3:0 are 0000. In that case `mem_addr` is `pc_out + 2`.
- R5: In all remaining cases `mem_addr` is `pc_out + 1`, wrapping at 16 bits.
- R6: A current word is multi-cycle when bits 15:9 are 1001000, when bits 15:8 are 10010101, when bits 15:10 are 100110 with bit 8 set, or when bits 15:10 are 111111. Such a word stalls the stage only while `first_cycle` is 1, so it holds the counter for exactly one cycle.
- R7: `first_cycle` is the inverse of the stall decision from the previous cycle. It is therefore never 0 on two consecutive cycles.
- R8: While `skip` is 1, `opc_out` is all zeros and no stall is raised.
- R9: While neither clear nor skip is active and `int_vec[5]` is 1, `opc_out` is 26 zero bits followed by the 6-bit `int_vec`, and no stall is raised. The insertion repeats on every cycle until bit 5 drops.
- R10: While neither clear nor skip is active and `int_vec[5]` is 0, `opc_out` equals `mem_opc`, and the low bits of `int_vec` have no effect.
- R11: Outside clear, `pc_out` equals the `mem_addr` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear and reset, active high |
| skip | input | 1 | Invalidate the current fetch from the execution stage |
| load_pc | input | 1 | Branch load request |
| new_pc | input | 16 | Branch target word address |
| int_vec | input | 6 | Interrupt request: bit 5 pending, bits 4:0 vector number |
| mem_addr | output | 16 | Word address that the program memory reads at this edge |
| mem_opc | input | 32 | Memory window: current word low, following word high |
| opc_out | output | 32 | Opcode handed to the decoder |
| first_cycle | output | 1 | 1 on the first cycle of an instruction |
| pc_out | output | 16 | Counter value that belongs to `opc_out` |

## Verification
Two pairs of functions can meet in the same cycle. A branch load can arrive while the current word is multi-cycle and on its first cycle. An interrupt or a skip can arrive on the same cycle as a multi-cycle or two-word opcode. The random stimulus draws load, skip, clear and interrupt independently every cycle. The program memory model is filled with a dense mix of two-word and multi-cycle encodings, so these collisions happen often. A reference model in the bench applies the stated precedence and judges each one: a stall beats a load, an invalidation or interrupt cancels the stall, and a two-word advance yields to a load.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int WORD_W = 16;
    localparam int N_LONG = 2;
    localparam int N_MULTI = 4;

    // two-word encodings: jump/call forms, direct load/store forms
    localparam logic [N_LONG-1:0][WORD_W-1:0] LONG_MASK = {16'hFE0C, 16'hFC0F};
    localparam logic [N_LONG-1:0][WORD_W-1:0] LONG_VAL  = {16'h940C, 16'h9000};

    // multi-cycle encodings
    localparam logic [N_MULTI-1:0][WORD_W-1:0] MULTI_MASK =
        {16'hFE00, 16'hFF00, 16'hFD00, 16'hFC00};
    localparam logic [N_MULTI-1:0][WORD_W-1:0] MULTI_VAL =
        {16'h9000, 16'h9500, 16'h9900, 16'hFC00};

    typedef enum logic [2:0] {
        SRC_ZERO,
        SRC_HOLD,
        SRC_LOAD,
        SRC_PLUS2,
        SRC_PLUS1
    } pc_src_e;

    typedef struct packed {
        logic clear;
        logic stall;
        logic load;
        logic two_word;
    } fetch_ctl_t;

    function automatic pc_src_e pick_src(fetch_ctl_t c);
        if (c.clear)         return SRC_ZERO;
        else if (c.stall)    return SRC_HOLD;
        else if (c.load)     return SRC_LOAD;
        else if (c.two_word) return SRC_PLUS2;
        else                 return SRC_PLUS1;
    endfunction

endpackage

// File: rtl/fetch_match.sv
module fetch_match #(
    parameter int N = 2,
    parameter int W = 16,
    parameter logic [N-1:0][W-1:0] MASKS = '0,
    parameter logic [N-1:0][W-1:0] VALUES = '0
) (
    input  logic [W-1:0] word,
    output logic         hit
);
    logic [N-1:0] hits;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pat
            assign hits[i] = ((word & MASKS[i]) == VALUES[i]);
        end
    endgenerate

    assign hit = |hits;
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  fetch_ctl_t      ctl,
    input  logic [PC_W-1:0] new_pc,
    output logic [PC_W-1:0] pc_q,
    output logic [PC_W-1:0] next_pc,
    output logic            first_q
);
    pc_src_e src;

    always_comb begin
        src = pick_src(ctl);
        unique case (src)
            SRC_ZERO:  next_pc = '0;
            SRC_HOLD:  next_pc = pc_q;
            SRC_LOAD:  next_pc = new_pc;
            SRC_PLUS2: next_pc = pc_q + PC_W'(2);
            default:   next_pc = pc_q + PC_W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        pc_q    <= next_pc;
        first_q <= ~ctl.stall;
    end
endmodule

// File: rtl/fetch_opc_sel.sv
module fetch_opc_sel #(
    parameter int OPC_W = 32,
    parameter int VEC_W = 6
) (
    input  logic             invalidate,
    input  logic [VEC_W-1:0] int_vec,
    input  logic [OPC_W-1:0] mem_opc,
    output logic [OPC_W-1:0] opc,
    output logic             irq
);
    localparam int PAD_W = OPC_W - VEC_W;

    assign irq = int_vec[VEC_W-1];

    always_comb begin
        if (invalidate)
            opc = '0;
        else if (irq)
            opc = {{PAD_W{1'b0}}, int_vec};
        else
            opc = mem_opc;
    end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int VEC_W = 6
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                skip,
    input  logic                load_pc,
    input  logic [PC_W-1:0]     new_pc,
    input  logic [VEC_W-1:0]    int_vec,
    output logic [PC_W-1:0]     mem_addr,
    input  logic [2*WORD_W-1:0] mem_opc,
    output logic [2*WORD_W-1:0] opc_out,
    output logic                first_cycle,
    output logic [PC_W-1:0]     pc_out
);
    localparam int OPC_W = 2 * WORD_W;

    logic            invalidate;
    logic            irq;
    logic            long_hit;
    logic            multi_hit;
    logic            first_q;
    logic [PC_W-1:0] pc_q;
    fetch_ctl_t      ctl;

    assign invalidate = clr | skip;

    fetch_match #(
        .N(N_LONG), .W(WORD_W), .MASKS(LONG_MASK), .VALUES(LONG_VAL)
    ) u_long (
        .word(mem_opc[WORD_W-1:0]),
        .hit (long_hit)
    );

    fetch_match #(
        .N(N_MULTI), .W(WORD_W), .MASKS(MULTI_MASK), .VALUES(MULTI_VAL)
    ) u_multi (
        .word(mem_opc[WORD_W-1:0]),
        .hit (multi_hit)
    );

    fetch_opc_sel #(
        .OPC_W(OPC_W), .VEC_W(VEC_W)
    ) u_sel (
        .invalidate(invalidate),
        .int_vec   (int_vec),
        .mem_opc   (mem_opc),
        .opc       (opc_out),
        .irq       (irq)
    );

    always_comb begin
        ctl.clear    = clr;
        ctl.stall    = ~invalidate & ~irq & multi_hit & first_q;
        ctl.load     = load_pc;
        ctl.two_word = long_hit;
    end

    fetch_pc_unit #(
        .PC_W(PC_W)
    ) u_pc (
        .clk    (clk),
        .ctl    (ctl),
        .new_pc (new_pc),
        .pc_q   (pc_q),
        .next_pc(mem_addr),
        .first_q(first_q)
    );

    assign pc_out      = pc_q;
    assign first_cycle = first_q;
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
    parameter int PC_W = 16,
    parameter int VEC_W = 6,
    parameter int OPC_W = 32
) (
    input logic             clk,
    input logic             clr,
    input logic             skip,
    input logic [VEC_W-1:0] int_vec,
    input logic [PC_W-1:0]  mem_addr,
    input logic [OPC_W-1:0] opc_out,
    input logic             first_cycle,
    input logic [PC_W-1:0]  pc_out
);
    a_r1_clear_zero: assert property (@(posedge clk)
        clr |=> (pc_out == '0 && first_cycle));

    a_r1_clear_nop: assert property (@(posedge clk)
        clr |-> (opc_out == '0 && mem_addr == '0));

    a_r2_stall_hold: assert property (@(posedge clk) disable iff (clr)
        !first_cycle |-> (pc_out == $past(pc_out)));

    a_r7_single_wait: assert property (@(posedge clk) disable iff (clr)
        !first_cycle |=> first_cycle);

    a_r8_skip_nop: assert property (@(posedge clk) disable iff (clr)
        skip |-> (opc_out == '0));

    a_r9_irq_opcode: assert property (@(posedge clk) disable iff (clr)
        (!skip && int_vec[VEC_W-1]) |-> (opc_out == {{(OPC_W-VEC_W){1'b0}}, int_vec}));

    a_r11_pc_delay: assert property (@(posedge clk) disable iff (clr)
        pc_out == $past(mem_addr));
endmodule

bind fetch_seq fetch_seq_chk #(
    .PC_W(PC_W), .VEC_W(VEC_W), .OPC_W(2 * fetch_pkg::WORD_W)
) u_chk (
    .clk        (clk),
    .clr        (clr),
    .skip       (skip),
    .int_vec    (int_vec),
    .mem_addr   (mem_addr),
    .opc_out    (opc_out),
    .first_cycle(first_cycle),
    .pc_out     (pc_out)
);

// File: tb/fetch_seq_tb_top.sv
module fetch_seq_tb_top;
    localparam int CYCLES = 4000;

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic        skip = 1'b0;
    logic        load_pc = 1'b0;
    logic [15:0] new_pc = '0;
    logic [5:0]  int_vec = '0;
    logic [15:0] mem_addr;
    logic [31:0] mem_opc;
    logic [31:0] opc_out;
    logic        first_cycle;
    logic [15:0] pc_out;

    logic [15:0] prog [256];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fetch_seq dut_i (
        .clk(clk), .clr(clr), .skip(skip), .load_pc(load_pc), .new_pc(new_pc),
        .int_vec(int_vec), .mem_addr(mem_addr), .mem_opc(mem_opc),
        .opc_out(opc_out), .first_cycle(first_cycle), .pc_out(pc_out)
    );

    // program memory model, one cycle read latency
    always_ff @(posedge clk)
        mem_opc <= {prog[8'(mem_addr[7:0] + 8'd1)], prog[mem_addr[7:0]]};

    function automatic bit two_word_f(logic [15:0] w);
        return (w[15:9] == 7'b1001010 && w[3:2] == 2'b11) ||
               (w[15:10] == 6'b100100 && w[3:0] == 4'b0000);
    endfunction

    function automatic bit multi_f(logic [15:0] w);
        return (w[15:9] == 7'b1001000) || (w[15:8] == 8'b10010101) ||
               (w[15:10] == 6'b100110 && w[8]) || (w[15:10] == 6'b111111);
    endfunction

    function automatic logic [15:0] gen_word();
        int k = int'($urandom_range(0, 5));
        logic [15:0] r = 16'($urandom);
        case (k)
            0: return {7'b1001010, r[8:4], 2'b11, r[1:0]};
            1: return {6'b100100, r[9:4], 4'b0000};
            2: return {7'b1001000, r[8:0]};
            3: return {8'b10010101, r[7:0]};
            4: return {6'b100110, r[9], 1'b1, r[7:0]};
            default: return r;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] m_pc = '0;
        bit m_first = 1'b1;
        bit m_valid = 1'b0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) prog[i] = gen_word();
        // directed opening: nop, jump(long), operand, return(multi),
        // direct load (long and multi), operand, bit-test skip (multi), plain
        prog[0] = 16'h0000; prog[1] = 16'h940C; prog[2] = 16'h1111;
        prog[3] = 16'h9508; prog[4] = 16'h9000; prog[5] = 16'h2222;
        prog[6] = 16'hFC00; prog[7] = 16'h0C01; prog[8] = 16'h0000;

        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            logic [15:0] w0, w1, nxt;
            logic [31:0] eopc;
            bit inv, iv, stall;
            string tag_addr, tag_opc;
            @(negedge clk);
            if (cyc < 2) begin
                clr = 1'b1; skip = 1'b0; load_pc = 1'b0; int_vec = 6'h1F;
            end else if (cyc < 30) begin
                clr = 1'b0; skip = 1'b0; load_pc = 1'b0; int_vec = 6'h15;
            end else begin
                clr = ($urandom_range(0, 99) < 2);
                skip = ($urandom_range(0, 99) < 10);
                load_pc = ($urandom_range(0, 99) < 10);
                new_pc = ($urandom_range(0, 9) == 0) ? 16'hFFFF : 16'($urandom);
                int_vec = 6'($urandom);
                int_vec[5] = ($urandom_range(0, 99) < 8);
            end
            #1;
            inv = clr | skip;
            iv = int_vec[5];
            if (m_valid) begin
                w0 = prog[m_pc[7:0]];
                w1 = prog[8'(m_pc[7:0] + 8'd1)];
            end else begin
                w0 = '0; w1 = '0;
            end
            stall = !inv && !iv && multi_f(w0) && m_first;
            if (clr) begin
                nxt = '0; tag_addr = "R1 clear address";
            end else if (stall) begin
                nxt = m_pc; tag_addr = load_pc ? "R2 stall beats load" : "R6 multi-cycle hold";
            end else if (load_pc) begin
                nxt = new_pc; tag_addr = "R3 branch load";
            end else if (two_word_f(w0)) begin
                nxt = m_pc + 16'd2; tag_addr = "R4 two-word advance";
            end else begin
                nxt = m_pc + 16'd1; tag_addr = "R5 single advance";
            end
            if (clr) begin
                eopc = '0; tag_opc = "R1 clear no-op";
            end else if (skip) begin
                eopc = '0; tag_opc = "R8 skip no-op";
            end else if (iv) begin
                eopc = {26'd0, int_vec}; tag_opc = "R9 interrupt opcode";
            end else begin
                eopc = {w1, w0}; tag_opc = "R10 pass-through";
            end
            if (m_valid || clr) begin
                check(tag_opc, opc_out, eopc);
                check(tag_addr, 32'(mem_addr), 32'(nxt));
            end
            if (m_valid) begin
                check("R11 pc alignment", 32'(pc_out), 32'(m_pc));
                check("R7 first-cycle flag", 32'(first_cycle), 32'(m_first));
            end
            if (clr) begin
                m_pc = '0; m_first = 1'b1; m_valid = 1'b1;
            end else if (m_valid) begin
                m_pc = nxt; m_first = !stall;
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule